// File: doc/BRIEF.md
# Lock-after-first-write watchdog timer

This block is a watchdog countdown timer controlled through a single write-only word at one bus offset. The first write to that offset after reset sets the whole timer up: a 12-bit reload count, a choice of whether a divide-by-16384 stage sits in front of the counter, a run enable, and a 2-bit code that says how an expiry is reported. That write also starts the countdown. From then on the setup is frozen. Any further write to the same offset, whatever data it carries, only reloads the counter from the stored count. Software has no way to lengthen, shorten or stop a running watchdog.

The counter advances on an internal enable that fires on every second bus clock. When the divide stage is selected, the counter also waits for 16384 of those enables between steps. When the count reaches zero the block reports expiry. It raises an interrupt request if the reporting code is 2, and a reset request for any other code. The output stays high until the next restart write or a system reset. A system reset is the only thing that unlocks the setup.

Top module: `oneshot_cfg_wdt`

## Requirements
- R1: After reset `irq` and `rst_req` are both low and the setup is unlocked, so the next write to the register offset is taken as the setup.
- R2: The first write to offset 0 stores the setup from `wr_data`: bits [11:0] reload count, bit 12 divide-stage select, bit 13 run enable, bits [15:14] reporting code. The same write loads the counter and starts the countdown.
- R3: With the divide stage off and a reload count R, the expiry output is low in the cycle that follows 2R clock edges after the write edge, and high after 2R+1 edges.
- R4: With the divide stage on and a reload count R, the expiry output rises 2·16384·R+1 clock edges after the write edge and is low one edge earlier.
- R5: Reporting code 2 drives `irq`; codes 0, 1 and 3 drive `rst_req`; the two outputs are never high together.
- R6: After the setup write, each write to offset 0 restarts the countdown from the stored reload count, and its data changes neither the count, the enable nor the reporting code.
- R7: Writes to any offset other than 0 are ignored: they neither set up nor restart the timer.
- R8: If the setup write clears the run enable, the timer never expires, and later writes cannot turn it on.
- R9: Once raised, the expiry output stays high while no restart write arrives. A restart write drops it at the same edge that accepts the write.
- R10: Only a system reset unlocks the setup. After a reset a new setup write takes effect with new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W (8) | Byte offset of the write |
| wr_data | input | DATA_W (32) | Write data; only bits [15:0] are used |
| irq | output | 1 | Expiry interrupt request (reporting code 2) |
| rst_req | output | 1 | Expiry reset request (any other reporting code) |

## Verification
The hardest state to reach from the ports is "already locked", because it can be entered only once per reset and then hides every field written afterwards. The stimulus therefore resets the block before each table vector. It runs each setup through to a measured expiry edge. Directed sequences then write conflicting data after the lock and show that the expiry edge and the chosen output stay those of the first write. The divide stage is reached with a reload count of 1, so its 32769-edge window stays short.

// File: rtl/oneshot_cfg_wdt_pkg.sv
package oneshot_cfg_wdt_pkg;

  // Field layout of the control word (fixed by the register format).
  localparam int RELOAD_W   = 12;
  localparam int MODE_W     = 2;
  localparam int CFG_W      = RELOAD_W + 2 + MODE_W;
  localparam int PRE_BIT    = RELOAD_W;
  localparam int EN_BIT     = RELOAD_W + 1;
  localparam int MODE_LSB   = RELOAD_W + 2;
  localparam logic [MODE_W-1:0] MODE_IRQ = 2'd2;

  typedef struct packed {
    logic [MODE_W-1:0]   mode;
    logic                enable;
    logic                prescale;
    logic [RELOAD_W-1:0] reload;
  } wdt_cfg_t;

  function automatic wdt_cfg_t unpack_cfg(input logic [CFG_W-1:0] word);
    wdt_cfg_t c;
    c.reload   = word[RELOAD_W-1:0];
    c.prescale = word[PRE_BIT];
    c.enable   = word[EN_BIT];
    c.mode     = word[MODE_LSB +: MODE_W];
    return c;
  endfunction

  function automatic logic routes_to_irq(input logic [MODE_W-1:0] mode);
    return (mode == MODE_IRQ);
  endfunction

  // Clock edges from the accepting write edge to the expiry edge.
  function automatic longint unsigned expiry_edges(input int unsigned reload,
                                                   input logic pre,
                                                   input int unsigned div);
    longint unsigned per_step;
    per_step = pre ? 2 * longint'(div) : 2;
    return per_step * reload + 1;
  endfunction

endpackage

// File: rtl/oneshot_cfg_wdt_cfg.sv
module oneshot_cfg_wdt_cfg
  import oneshot_cfg_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [CFG_W-1:0] wr_word,
  output wdt_cfg_t         cfg,
  output logic             locked,
  output logic             cfg_wr,
  output logic             retrig
);

  assign cfg_wr = wr_hit && !locked;
  assign retrig = wr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      locked <= 1'b0;
    end else if (cfg_wr) begin
      cfg    <= unpack_cfg(wr_word);
      locked <= 1'b1;
    end
  end

endmodule

// File: rtl/oneshot_cfg_wdt_tick.sv
module oneshot_cfg_wdt_tick #(
  parameter int DIV = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic pre_sel,
  output logic half_en,
  output logic step
);

  logic phase;

  // Half-rate enable, phase realigned by every restart.
  always_ff @(posedge clk) begin
    if (!rst_n || restart) phase <= 1'b0;
    else                   phase <= ~phase;
  end
  assign half_en = phase;

  generate
    if (DIV <= 1) begin : g_nodiv
      assign step = half_en;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pcnt;
      logic          wrap;

      assign wrap = (pcnt == LAST);

      always_ff @(posedge clk) begin
        if (!rst_n || restart || !pre_sel) pcnt <= '0;
        else if (half_en)                  pcnt <= wrap ? '0 : pcnt + 1'b1;
      end

      assign step = half_en && (!pre_sel || wrap);
    end
  endgenerate

endmodule

// File: rtl/oneshot_cfg_wdt_count.sv
module oneshot_cfg_wdt_count
  import oneshot_cfg_wdt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic [RELOAD_W-1:0] load_val,
  input  logic                run,
  input  logic                step,
  output logic [RELOAD_W-1:0] count,
  output logic                fired
);

  logic at_zero;
  assign at_zero = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      fired <= 1'b0;
    end else if (restart) begin
      count <= load_val;
      fired <= 1'b0;
    end else begin
      if (run && step && !at_zero) count <= count - 1'b1;
      if (run && at_zero)          fired <= 1'b1;
    end
  end

endmodule

// File: rtl/oneshot_cfg_wdt.sv
module oneshot_cfg_wdt
  import oneshot_cfg_wdt_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int REG_OFFSET   = 0,
  parameter int PRESCALE_DIV = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq,
  output logic              rst_req
);

  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

  logic                wr_hit;
  logic [CFG_W-1:0]    wr_word;
  wdt_cfg_t            cfg;
  logic                locked;
  logic                cfg_wr;
  logic                retrig;
  logic                run;
  logic                half_en;
  logic                step;
  logic [RELOAD_W-1:0] load_val;
  logic [RELOAD_W-1:0] count;
  logic                fired;
  logic [CFG_W-1:0]    cfg_bits;
  logic                unused_hi;

  assign wr_hit    = wr_en && (wr_addr == OFFS);
  assign wr_word   = wr_data[CFG_W-1:0];
  assign unused_hi = ^wr_data[DATA_W-1:CFG_W];
  assign cfg_bits  = cfg;

  oneshot_cfg_wdt_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (wr_hit),
    .wr_word (wr_word),
    .cfg     (cfg),
    .locked  (locked),
    .cfg_wr  (cfg_wr),
    .retrig  (retrig)
  );

  // The setup write carries its own reload count; later writes use the stored one.
  assign load_val = cfg_wr ? unpack_cfg(wr_word).reload : cfg.reload;
  assign run      = locked && cfg.enable;

  oneshot_cfg_wdt_tick #(.DIV(PRESCALE_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (retrig),
    .pre_sel (cfg.prescale),
    .half_en (half_en),
    .step    (step)
  );

  oneshot_cfg_wdt_count u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (retrig),
    .load_val (load_val),
    .run      (run),
    .step     (step),
    .count    (count),
    .fired    (fired)
  );

  assign irq     = fired &&  routes_to_irq(cfg.mode);
  assign rst_req = fired && !routes_to_irq(cfg.mode);

endmodule

// File: rtl/oneshot_cfg_wdt_chk.sv
module oneshot_cfg_wdt_chk
  import oneshot_cfg_wdt_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                irq,
  input logic                rst_req,
  input logic                locked,
  input logic                retrig,
  input logic                run,
  input logic                fired,
  input logic [RELOAD_W-1:0] count,
  input logic [CFG_W-1:0]    cfg_bits
);

  AST_NO_DUAL_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n) !(irq && rst_req)); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) locked |=> $stable(cfg_bits)); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) locked |=> locked); // R10
  AST_FIRE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (fired && !retrig) |=> fired); // R9
  AST_RETRIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) retrig |=> !fired); // R9
  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (count == '0 && !retrig) |=> count == '0); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (locked && !run) |-> (!irq && !rst_req)); // R8

endmodule

bind oneshot_cfg_wdt oneshot_cfg_wdt_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .rst_req  (rst_req),
  .locked   (locked),
  .retrig   (retrig),
  .run      (run),
  .fired    (fired),
  .count    (count),
  .cfg_bits (cfg_bits)
);

// File: tb/oneshot_cfg_wdt_tb.sv
`timescale 1ns/1ps
module oneshot_cfg_wdt_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        irq, rst_req;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  oneshot_cfg_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq(irq), .rst_req(rst_req)
  );

  // {expect irq (1) or rst_req (0), control word}
  localparam logic [16:0] VEC [5] = '{
    {1'b1, 16'hA005},
    {1'b0, 16'h2003},
    {1'b0, 16'h6001},
    {1'b1, 16'hA000},
    {1'b0, 16'hE007}
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {irq,rst_req} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    adv(2);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic logic [1:0] out_for(input logic [1:0] mode);
    return (mode == 2'd2) ? 2'b10 : 2'b01;
  endfunction

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset", {irq, rst_req}, 2'b00);

    // Table walk: each vector gets a fresh reset (R10) and a setup write (R2).
    for (int v = 0; v < 5; v++) begin
      int unsigned r;
      logic [1:0]  exp_out;
      do_reset();
      r = int'(VEC[v][11:0]);
      exp_out = VEC[v][16] ? 2'b10 : 2'b01;
      if (exp_out != out_for(VEC[v][15:14])) $display("table inconsistent");
      wr(8'h00, {16'h0, VEC[v][15:0]});
      adv(2 * r);
      chk("R3 before expiry", {irq, rst_req}, 2'b00);
      adv(1);
      chk("R5/R10 expiry routing", {irq, rst_req}, exp_out);
    end

    // R9: output holds, restart drops it at the accepting edge.
    adv(50);
    chk("R9 hold", {irq, rst_req}, 2'b01);
    wr(8'h00, 32'h0);
    chk("R9 cleared by restart", {irq, rst_req}, 2'b00);

    // R6: later write with other data restarts from stored count and keeps mode.
    do_reset();
    wr(8'h00, 32'h0000_A004);
    adv(5);
    wr(8'h00, 32'h0000_2064);
    adv(8);
    chk("R6 restart keeps reload", {irq, rst_req}, 2'b00);
    adv(1);
    chk("R6 mode unchanged", {irq, rst_req}, 2'b10);

    // R7: stray offset before setup does nothing; after setup does not restart.
    do_reset();
    wr(8'h04, 32'h0000_A001);
    adv(10);
    chk("R7 stray write no setup", {irq, rst_req}, 2'b00);
    wr(8'h00, 32'h0000_2006);
    adv(4);
    wr(8'h10, 32'h0);
    adv(7);
    chk("R7 stray write no restart pre", {irq, rst_req}, 2'b00);
    adv(1);
    chk("R7 stray write no restart", {irq, rst_req}, 2'b01);

    // R8: disabled setup never runs, and cannot be enabled later.
    do_reset();
    wr(8'h00, 32'h0000_8000);
    adv(40);
    chk("R8 disabled idle", {irq, rst_req}, 2'b00);
    wr(8'h00, 32'h0000_A000);
    adv(40);
    chk("R8 enable locked out", {irq, rst_req}, 2'b00);

    // R4: divide stage with reload 1.
    do_reset();
    wr(8'h00, 32'h0000_B001);
    adv(2 * 16384);
    chk("R4 prescale before expiry", {irq, rst_req}, 2'b00);
    adv(1);
    chk("R4 prescale expiry", {irq, rst_req}, 2'b10);

    // R1 again: reset clears an active output.
    do_reset();
    chk("R1 reset clears output", {irq, rst_req}, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule